// File: doc/BRIEF.md
# Write-Through Level-One Data Cache

This block is the first-level data cache of a single core. It holds 16 KB of data in 256 sets of four ways, each line 16 bytes (four 32-bit words). A load that hits returns its word one cycle after acceptance. Every store goes out to the next-level cache bank over a simple request interface. A store that hits also updates the local copy. A store that misses never allocates a line. Each line has only a valid bit, so nothing is ever dirty and nothing is written back from this level.

A load miss sends a line request to the next level. That request carries the way the cache will overwrite, so the next level can keep an exact mirror of what this cache holds. Only one miss can be outstanding. The core is stalled until the line comes back, and then the requested word is returned. The next level can also clear any line at any time by naming its set and way.

Top module: `wt_l1_dcache`

## Requirements
- R1: Addresses are word granular. Bits [31:12] are the tag, [11:4] the set, [3:2] the word within the line, and [1:0] are ignored. A load that hits raises `resp_valid` in the cycle after acceptance with that word, and makes no request to the next level.
- R2: Every accepted store appears on the next-level port in its acceptance cycle, with `lo_req_valid`=1, `lo_req_we`=1 and the same address and data. A store is accepted only while `lo_req_ready` is high.
- R3: A store hit updates the cached word at the acceptance edge, so a later load to it returns the new value without a miss. A store miss leaves the arrays unchanged, so a later load to that address misses.
- R4: A load miss raises `lo_req_valid` with `lo_req_we`=0 and the load address. It is accepted only while `lo_req_ready` is high.
- R5: `lo_req_way` on a load miss is the lowest-numbered invalid way of the set. If all four ways are valid it is the set's rotating pointer. Every pointer is 0 after reset and becomes victim+1 (mod 4) after each refill that used it.
- R6: From acceptance of a load miss until the refill response, `req_ready` is low. When `lo_resp_valid` arrives, the line (word k in bits [32k+31:32k] of `lo_resp_line`) is installed valid in the reported way, and `resp_valid` rises in the next cycle with the requested word.
- R7: `inv_valid` clears the valid bit of (`inv_set`, `inv_way`) at the next edge. If it falls in a refill cycle for another way, both take effect. If it names the refilled way, the line ends invalid.
- R8: `lo_resp_valid` has no effect while no miss is outstanding.
- R9: After reset every line is invalid, no response is pending and `req_ready` is high whenever `lo_req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Core request present |
| req_we | input | 1 | 1 = store, 0 = load |
| req_addr | input | 32 | Byte address of the request |
| req_wdata | input | 32 | Store data |
| req_ready | output | 1 | Request accepted this cycle if valid |
| resp_valid | output | 1 | Load data valid |
| resp_rdata | output | 32 | Load data |
| lo_req_valid | output | 1 | Request to the next level |
| lo_req_we | output | 1 | 1 = store write-through, 0 = line fill |
| lo_req_addr | output | 32 | Request address |
| lo_req_wdata | output | 32 | Store data to the next level |
| lo_req_way | output | 2 | Way to be replaced on a line fill |
| lo_req_ready | input | 1 | Next level accepts the request |
| lo_resp_valid | input | 1 | Line fill data present |
| lo_resp_line | input | 128 | Line fill data |
| inv_valid | input | 1 | Invalidate command |
| inv_set | input | 8 | Set to invalidate |
| inv_way | input | 2 | Way to invalidate |

## Verification
The hardest case to reach from the ports is an invalidate that lands in the exact cycle a refill writes its line. The refill cycle is decided by the next-level model, not by the core. So the bench's next-level model issues the invalidate together with its own fill response, naming the refilled way and a neighbouring way on alternate fills. Another hard case is a rotating-pointer victim. That needs a set with all four ways valid, so the stimulus keeps eight tags cycling over only four sets while random invalidates reopen ways. A behavioural model compared on every clock tracks both cases.

// File: rtl/wt_l1_dcache.sv
module wt_l1_dcache #(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int LINE_WORDS = 4,
  parameter int WAYS       = 4,
  parameter int SETS       = 256
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         req_valid,
  input  logic                         req_we,
  input  logic [ADDR_W-1:0]            req_addr,
  input  logic [DATA_W-1:0]            req_wdata,
  output logic                         req_ready,
  output logic                         resp_valid,
  output logic [DATA_W-1:0]            resp_rdata,
  output logic                         lo_req_valid,
  output logic                         lo_req_we,
  output logic [ADDR_W-1:0]            lo_req_addr,
  output logic [DATA_W-1:0]            lo_req_wdata,
  output logic [$clog2(WAYS)-1:0]      lo_req_way,
  input  logic                         lo_req_ready,
  input  logic                         lo_resp_valid,
  input  logic [DATA_W*LINE_WORDS-1:0] lo_resp_line,
  input  logic                         inv_valid,
  input  logic [$clog2(SETS)-1:0]      inv_set,
  input  logic [$clog2(WAYS)-1:0]      inv_way
);
  localparam int BYTE_W = $clog2(DATA_W/8);
  localparam int WORD_W = $clog2(LINE_WORDS);
  localparam int IDX_W  = $clog2(SETS);
  localparam int WAY_W  = $clog2(WAYS);
  localparam int OFF_W  = WORD_W + BYTE_W;
  localparam int TAG_W  = ADDR_W - IDX_W - OFF_W;
  localparam int LINE_W = DATA_W * LINE_WORDS;

  logic [TAG_W-1:0]  tag_q  [SETS][WAYS];
  logic [LINE_W-1:0] data_q [SETS][WAYS];
  logic [WAYS-1:0]   vld_q  [SETS];
  logic [WAY_W-1:0]  rr_q   [SETS];

  logic              waiting_q, use_rr_q;
  logic [IDX_W-1:0]  miss_idx_q;
  logic [TAG_W-1:0]  miss_tag_q;
  logic [WORD_W-1:0] miss_word_q;
  logic [WAY_W-1:0]  miss_way_q;
  logic              resp_valid_q;
  logic [DATA_W-1:0] resp_rdata_q;

  logic [IDX_W-1:0]  idx;
  logic [TAG_W-1:0]  tag;
  logic [WORD_W-1:0] word;
  logic [WAYS-1:0]   hit_vec;
  logic              hit, use_rr;
  logic [WAY_W-1:0]  hit_way, victim;
  logic [DATA_W-1:0] hit_word, fill_word;
  logic              accept, ld_hit, st_hit, ld_miss, refill;

  assign idx  = req_addr[OFF_W +: IDX_W];
  assign tag  = req_addr[ADDR_W-1 -: TAG_W];
  assign word = req_addr[BYTE_W +: WORD_W];

  always_comb begin
    hit_way = '0;
    victim  = rr_q[idx];
    use_rr  = 1'b1;
    for (int w = WAYS-1; w >= 0; w--) begin
      hit_vec[w] = vld_q[idx][w] && (tag_q[idx][w] == tag);
      if (hit_vec[w]) hit_way = WAY_W'(w);
      if (!vld_q[idx][w]) begin
        victim = WAY_W'(w);
        use_rr = 1'b0;
      end
    end
  end

  assign hit       = |hit_vec;
  assign hit_word  = data_q[idx][hit_way][word*DATA_W +: DATA_W];
  assign fill_word = lo_resp_line[miss_word_q*DATA_W +: DATA_W];

  assign req_ready    = !waiting_q && (lo_req_ready || (!req_we && hit));
  assign lo_req_valid = req_valid && !waiting_q && (req_we || !hit);
  assign lo_req_we    = req_we;
  assign lo_req_addr  = req_addr;
  assign lo_req_wdata = req_wdata;
  assign lo_req_way   = victim;

  assign accept  = req_valid && req_ready;
  assign ld_hit  = accept && !req_we && hit;
  assign st_hit  = accept && req_we && hit;
  assign ld_miss = accept && !req_we && !hit;
  assign refill  = waiting_q && lo_resp_valid;

  assign resp_valid = resp_valid_q;
  assign resp_rdata = resp_rdata_q;

  always_ff @(posedge clk) begin
    if (st_hit) data_q[idx][hit_way][word*DATA_W +: DATA_W] <= req_wdata;
    if (refill) begin
      data_q[miss_idx_q][miss_way_q] <= lo_resp_line;
      tag_q[miss_idx_q][miss_way_q]  <= miss_tag_q;
    end
    if (ld_miss) begin
      miss_idx_q  <= idx;
      miss_tag_q  <= tag;
      miss_word_q <= word;
      miss_way_q  <= victim;
      use_rr_q    <= use_rr;
    end
    resp_rdata_q <= refill ? fill_word : hit_word;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) begin
        vld_q[s] <= '0;
        rr_q[s]  <= '0;
      end
      waiting_q    <= 1'b0;
      resp_valid_q <= 1'b0;
    end else begin
      if (refill) begin
        vld_q[miss_idx_q][miss_way_q] <= 1'b1;
        if (use_rr_q) rr_q[miss_idx_q] <= WAY_W'(miss_way_q + 1'b1);
      end
      if (inv_valid) vld_q[inv_set][inv_way] <= 1'b0;
      if (ld_miss) waiting_q <= 1'b1;
      else if (refill) waiting_q <= 1'b0;
      resp_valid_q <= ld_hit || refill;
    end
  end
endmodule

// File: rtl/wt_l1_dcache_chk.sv
module wt_l1_dcache_chk (
  input logic clk,
  input logic rst_n,
  input logic req_valid,
  input logic req_we,
  input logic req_ready,
  input logic resp_valid,
  input logic lo_req_valid,
  input logic lo_req_we,
  input logic lo_req_ready,
  input logic lo_resp_valid,
  input logic waiting
);
  // R2
  store_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && req_we |-> lo_req_valid && lo_req_we && lo_req_ready);

  // R6
  one_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    waiting |-> !req_ready && !lo_req_valid);

  // R6
  miss_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lo_req_valid && lo_req_ready && !lo_req_we |=> waiting && !req_ready);

  // R6
  refill_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    waiting && lo_resp_valid |=> resp_valid && !waiting);

  // R1
  resp_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> $past((req_valid && req_ready && !req_we) || (waiting && lo_resp_valid)));

  // R8
  stray_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !waiting && lo_resp_valid && !(req_valid && req_ready && !req_we) |=> !resp_valid && !waiting);
endmodule

bind wt_l1_dcache wt_l1_dcache_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_we(req_we),
  .req_ready(req_ready), .resp_valid(resp_valid), .lo_req_valid(lo_req_valid),
  .lo_req_we(lo_req_we), .lo_req_ready(lo_req_ready), .lo_resp_valid(lo_resp_valid),
  .waiting(waiting_q)
);

// File: tb/test_wt_l1_dcache.sv
module test_wt_l1_dcache;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_we = 1'b0;
  logic [31:0] req_addr = '0, req_wdata = '0;
  logic req_ready, resp_valid, lo_req_valid, lo_req_we;
  logic [31:0] resp_rdata, lo_req_addr, lo_req_wdata;
  logic [1:0] lo_req_way;
  logic lo_req_ready, lo_resp_valid, inv_valid;
  logic [127:0] lo_resp_line;
  logic [7:0] inv_set;
  logic [1:0] inv_way;

  always #(CLK_PERIOD/2) clk = ~clk;

  wt_l1_dcache i_wt_l1_dcache (.*);

  int n_chk = 0, n_fail = 0;
  int miss_cnt = 0, resp_cnt = 0;
  int miss_set_l, miss_way_l, miss_base_l;
  logic [31:0] last_resp;
  bit ready_mode = 0, lat_mode = 0, spurious_mode = 0, collide_mode = 0, inv_rand_mode = 0;
  int dinv_id = 0, dinv_set, dinv_way;

  bit          m_vld [256][4];
  int          m_tag [256][4];
  logic [31:0] m_dat [256][4][4];
  int          m_rr  [256];
  bit m_wait, m_userr, m_rv;
  int m_idx, m_tagq, m_word, m_way;
  logic [31:0] m_rd;
  string m_rtag;
  logic [31:0] mem [int unsigned];

  function automatic logic [31:0] memrd(int unsigned wa);
    if (mem.exists(wa)) return mem[wa];
    return (wa * 32'h9E3779B1) ^ 32'h5A5A0F0F;
  endfunction

  task automatic chk(bit ok, string rq, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s act=%h exp=%h at %0t", rq, what, act, exp, $time);
    end
  endtask

  task automatic finish_run;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  always @(negedge clk) begin
    int idx, tg, wd, hw, vic;
    bit hit, userr, e_ready, e_lov;
    if (!rst_n) begin
      for (int s = 0; s < 256; s++) begin
        m_rr[s] = 0;
        for (int w = 0; w < 4; w++) m_vld[s][w] = 0;
      end
      m_wait = 0; m_rv = 0;
    end else begin
      idx = int'(req_addr[11:4]); tg = int'(req_addr[31:12]); wd = int'(req_addr[3:2]);
      hit = 0; hw = 0;
      for (int w = 0; w < 4; w++)
        if (m_vld[idx][w] && m_tag[idx][w] == tg) begin hit = 1; hw = w; end
      vic = -1;
      for (int w = 3; w >= 0; w--) if (!m_vld[idx][w]) vic = w;
      userr = (vic < 0);
      if (userr) vic = m_rr[idx];
      e_ready = !m_wait && (lo_req_ready || (!req_we && hit));
      e_lov   = req_valid && !m_wait && (req_we || !hit);
      chk(req_ready === e_ready, "R6", "req_ready", 32'(req_ready), 32'(e_ready));
      chk(lo_req_valid === e_lov, req_we ? "R2" : "R4", "lo_req_valid", 32'(lo_req_valid), 32'(e_lov));
      if (e_lov) begin
        chk(lo_req_we === req_we, req_we ? "R2" : "R4", "lo_req_we", 32'(lo_req_we), 32'(req_we));
        chk(lo_req_addr === req_addr, req_we ? "R2" : "R4", "lo_req_addr", lo_req_addr, req_addr);
        if (req_we) chk(lo_req_wdata === req_wdata, "R2", "lo_req_wdata", lo_req_wdata, req_wdata);
        else chk(lo_req_way === 2'(vic), "R5", "lo_req_way", 32'(lo_req_way), 32'(vic));
      end
      chk(resp_valid === m_rv, "R1", "resp_valid", 32'(resp_valid), 32'(m_rv));
      if (m_rv) chk(resp_rdata === m_rd, m_rtag, "resp_rdata", resp_rdata, m_rd);
      if (resp_valid) begin last_resp = resp_rdata; resp_cnt++; end
      m_rv = 0;
      if (req_valid && e_ready) begin
        if (req_we) begin
          mem[req_addr >> 2] = req_wdata;
          if (hit) m_dat[idx][hw][wd] = req_wdata;
        end else if (hit) begin
          m_rv = 1; m_rd = m_dat[idx][hw][wd]; m_rtag = "R1";
        end else begin
          m_wait = 1; m_idx = idx; m_tagq = tg; m_word = wd; m_way = vic; m_userr = userr;
          miss_set_l = idx; miss_way_l = vic; miss_base_l = int'(req_addr >> 4) << 2;
          miss_cnt++;
        end
      end else if (m_wait && lo_resp_valid) begin
        for (int k = 0; k < 4; k++) m_dat[m_idx][m_way][k] = lo_resp_line[32*k +: 32];
        m_tag[m_idx][m_way] = m_tagq;
        m_vld[m_idx][m_way] = 1;
        if (m_userr) m_rr[m_idx] = (m_way + 1) % 4;
        m_rv = 1; m_rd = lo_resp_line[32*m_word +: 32]; m_rtag = "R6";
        m_wait = 0;
      end
      if (inv_valid) m_vld[int'(inv_set)][int'(inv_way)] = 0;
    end
  end

  initial begin : lower
    int pend, cnt, seen, pset, pway, base, dseen;
    bit flip;
    lo_req_ready = 1'b1; lo_resp_valid = 1'b0; lo_resp_line = '0;
    inv_valid = 1'b0; inv_set = '0; inv_way = '0;
    seen = 0; dseen = 0; pend = 0; cnt = 0; flip = 0; pset = 0; pway = 0; base = 0;
    forever begin
      @(posedge clk); #1;
      lo_resp_valid = 1'b0; inv_valid = 1'b0;
      if (miss_cnt != seen) begin
        seen = miss_cnt; pend = 1; cnt = lat_mode ? int'($urandom % 4) : 1;
        pset = miss_set_l; pway = miss_way_l; base = miss_base_l;
      end
      if (pend != 0) begin
        if (cnt == 0) begin
          lo_resp_valid = 1'b1;
          for (int k = 0; k < 4; k++) lo_resp_line[32*k +: 32] = memrd(base + k);
          pend = 0;
          if (collide_mode) begin
            inv_valid = 1'b1; inv_set = 8'(pset);
            inv_way = flip ? 2'(pway) : 2'(pway ^ 1);
            flip = !flip;
          end
        end else cnt--;
      end else if (spurious_mode && ($urandom % 3 == 0)) begin
        lo_resp_valid = 1'b1;
        lo_resp_line = {$urandom, $urandom, $urandom, $urandom};
      end
      if (dinv_id != dseen) begin
        dseen = dinv_id; inv_valid = 1'b1; inv_set = 8'(dinv_set); inv_way = 2'(dinv_way);
      end else if (!inv_valid && inv_rand_mode && ($urandom % 6 == 0)) begin
        inv_valid = 1'b1; inv_set = 8'($urandom % 4); inv_way = 2'($urandom % 4);
      end
      lo_req_ready = ready_mode ? ($urandom % 3 != 0) : 1'b1;
    end
  end

  task automatic core_op(bit we, logic [31:0] a, logic [31:0] d);
    req_valid = 1'b1; req_we = we; req_addr = a; req_wdata = d;
    forever begin
      @(negedge clk);
      if (req_ready) break;
    end
    @(posedge clk); #1;
    req_valid = 1'b0;
  endtask

  task automatic load_wait(logic [31:0] a);
    int r0;
    r0 = resp_cnt;
    core_op(1'b0, a, '0);
    while (resp_cnt == r0) @(posedge clk);
    #1;
  endtask

  function automatic logic [31:0] ad(int t);
    return {20'(t), 8'h05, 2'd1, 2'b00};
  endfunction

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    n_fail++;
    $display("FAIL R6 watchdog act=hung exp=done");
    finish_run();
  end

  initial begin : main
    int m0, r0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(req_ready === 1'b1, "R9", "req_ready in reset", 32'(req_ready), 1);
    chk(resp_valid === 1'b0, "R9", "resp_valid in reset", 32'(resp_valid), 0);
    @(posedge clk); #1; rst_n = 1'b1;
    @(posedge clk); #1;

    m0 = miss_cnt;
    load_wait(ad(1));
    chk(miss_cnt == m0 + 1, "R9", "first load misses", 32'(miss_cnt - m0), 1);
    chk(miss_way_l == 0, "R5", "way into empty set", 32'(miss_way_l), 0);
    chk(last_resp === memrd(ad(1) >> 2), "R6", "fill word", last_resp, memrd(ad(1) >> 2));
    m0 = miss_cnt;
    load_wait(ad(1));
    chk(miss_cnt == m0, "R1", "hit makes no request", 32'(miss_cnt - m0), 0);
    chk(last_resp === memrd(ad(1) >> 2), "R1", "hit word", last_resp, memrd(ad(1) >> 2));

    core_op(1'b1, ad(1), 32'hCAFEF00D);
    m0 = miss_cnt;
    load_wait(ad(1));
    chk(last_resp === 32'hCAFEF00D, "R3", "store hit updates", last_resp, 32'hCAFEF00D);
    chk(miss_cnt == m0, "R3", "store hit keeps line", 32'(miss_cnt - m0), 0);

    core_op(1'b1, ad(2), 32'h12345678);
    m0 = miss_cnt;
    load_wait(ad(2));
    chk(miss_cnt == m0 + 1, "R3", "store miss no allocate", 32'(miss_cnt - m0), 1);
    chk(miss_way_l == 1, "R5", "second invalid way", 32'(miss_way_l), 1);
    chk(last_resp === 32'h12345678, "R2", "store reached next level", last_resp, 32'h12345678);

    load_wait(ad(3));
    load_wait(ad(4));
    load_wait(ad(5));
    chk(miss_way_l == 0, "R5", "rotating victim first", 32'(miss_way_l), 0);
    load_wait(ad(6));
    chk(miss_way_l == 1, "R5", "rotating victim second", 32'(miss_way_l), 1);

    dinv_set = 5; dinv_way = 2; dinv_id++;
    repeat (3) @(posedge clk); #1;
    m0 = miss_cnt;
    load_wait(ad(3));
    chk(miss_cnt == m0 + 1, "R7", "invalidated line misses", 32'(miss_cnt - m0), 1);
    chk(miss_way_l == 2, "R5", "invalid way preferred", 32'(miss_way_l), 2);

    spurious_mode = 1;
    r0 = resp_cnt;
    repeat (30) @(posedge clk); #1;
    chk(resp_cnt == r0, "R8", "stray fill ignored", 32'(resp_cnt - r0), 0);
    m0 = miss_cnt;
    load_wait(ad(6));
    chk(miss_cnt == m0, "R8", "line kept after stray fill", 32'(miss_cnt - m0), 0);
    spurious_mode = 0;

    collide_mode = 1;
    for (int i = 0; i < 40; i++) load_wait({20'(i % 8), 8'h09, 2'(i % 4), 2'b00});
    collide_mode = 0;

    ready_mode = 1; lat_mode = 1; inv_rand_mode = 1; collide_mode = 1;
    for (int i = 0; i < 3000; i++) begin
      if (i % 500 == 250) spurious_mode = !spurious_mode;
      core_op(1'b0 + ($urandom % 3 == 0),
              {20'($urandom % 8), 8'($urandom % 4), 2'($urandom % 4), 2'b00}, $urandom);
    end
    ready_mode = 0; lat_mode = 0; inv_rand_mode = 0; collide_mode = 0; spurious_mode = 0;
    repeat (10) @(posedge clk);
    finish_run();
  end
endmodule